// File: doc/BRIEF.md
# Boundary-Scan Pin Cell Chain

This block is the serial chain of boundary cells that sits between a chip's core logic and its pins. It holds one cell per pin: a bidirectional pin gets three scan stages (driver enable, driver data, pad sample) and two update stages, while an input-only pin gets one combined sample/shift stage. A test access port controller outside the block supplies the shift, clock and update strobes on the test clock. Test data enters at `tdi`, moves through every stage in a fixed order, and leaves at `tdo`.

In normal operation the core's enable and data reach the pins untouched. When external test or programming mode is selected, the pins are driven from the update stages instead. A high-impedance request, or the active-low test output enable, turns off every pin driver whatever else is selected. Shift and capture happen on the rising test-clock edge. The update stages and the serial output change on the falling edge, so both are stable for the whole next rising edge.

Top module: `bsc_chain`

## Requirements
- R1: When `shift_dr` and `clock_dr` are both high at a rising edge of `tck`, every stage takes the value of the stage before it, and the first stage takes `tdi`.
- R2: When `clock_dr` is high and `shift_dr` is low at a rising edge, the stages load in parallel: enable stage of pin b from `core_oe[b]`, data stage from `core_do[b]`, sample stage from `pad_in[b]`, and input stage j from `in_pin[j]`.
- R3: When `clock_dr` is low at a rising edge, no scan stage changes. `tdi` and `shift_dr` have no effect, and `tdo` holds.
- R4: At a falling edge of `tck` with `update_dr` high, the update stages of each bidirectional pin take that pin's enable and data scan stages. With `update_dr` low they hold.
- R5: With `rst_n` low, the scan stages clear at the rising edge, and the update stages and `tdo` clear at the falling edge.
- R6: With `extest` or `prog_mode` high, `pad_oe` and `pad_do` come from the update stages. With both low, they equal `core_oe` and `core_do`.
- R7: With `highz` high, every bit of `pad_oe` is 0.
- R8: With `toe_n` low, every bit of `pad_oe` is 0.
- R9: `tdo` changes only at falling edges, where it takes the value of the last scan stage.
- R10: The chain order from `tdi` is as follows. Bidirectional pins come first in index order, each contributing its enable, data and sample stages in that order. Input-only pins follow in index order. The last input stage feeds `tdo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset of scan and update stages |
| shift_dr | input | 1 | Selects serial shift instead of parallel load |
| clock_dr | input | 1 | Enables the scan stages at a rising edge |
| update_dr | input | 1 | Enables the update stages at a falling edge |
| tdi | input | 1 | Serial test data into the first stage |
| extest | input | 1 | External-test override onto the pins |
| prog_mode | input | 1 | Programming-mode override onto the pins |
| highz | input | 1 | Forces all pin drivers off |
| toe_n | input | 1 | Active-low test output enable; low turns off all drivers |
| core_oe | input | NUM_BIDIR | Core driver enable per bidirectional pin |
| core_do | input | NUM_BIDIR | Core output data per bidirectional pin |
| pad_in | input | NUM_BIDIR | Value seen on each bidirectional pad |
| in_pin | input | NUM_INPUT | Value on each input-only pin |
| pad_oe | output | NUM_BIDIR | Driver enable to each bidirectional pad |
| pad_do | output | NUM_BIDIR | Driver data to each bidirectional pad |
| tdo | output | 1 | Serial test data out, changes on the falling edge |

## Verification
The hardest case to reach is a pin driven from its update stage with a value that differs from what the core drives. This needs a chosen pattern shifted over exactly the right number of edges, an update pulse on a falling edge, and then the override selected while the core drives the opposite value. The stimulus fills the whole chain serially and pulses update. It then runs external test and programming mode with inverted core values, and later repeats this at random with update pulses scattered among shifts and parallel loads. A complete capture followed by a full-length shift-out checks every position of the chain order.

// File: rtl/bsc_pkg.sv
`timescale 1ns/1ps
// Package: shared helpers for the boundary-scan pin chain.
// Assumes three scan stages per bidirectional pin and one per input pin.
package bsc_pkg;
    localparam int STAGES_PER_BIDIR = 3;
    localparam int STAGE_EN  = 0;
    localparam int STAGE_DO  = 1;
    localparam int STAGE_CAP = 2;

    // Pin override controls grouped for routing to every cell.
    typedef struct packed {
        logic use_bscan;  // drive from update stages
        logic drv_kill;   // force driver off
    } pin_ovr_t;

    // Total serial length of the chain.
    function automatic int chain_len(input int nb, input int ni);
        return STAGES_PER_BIDIR * nb + ni;
    endfunction
endpackage

// File: rtl/bsc_bidir_cell.sv
`timescale 1ns/1ps
// Boundary cell for one bidirectional pin.
// Three scan stages (enable, data, pad sample) shift from scan_in to
// scan_out on the rising test-clock edge when clock_dr is high. Two update
// stages take the enable and data stages on the falling edge when update_dr
// is high. The pin driver is muxed between core values and update values.
// Assumes strobes are stable around both clock edges.
module bsc_bidir_cell
    import bsc_pkg::*;
(
    input  logic     tck,
    input  logic     rst_n,
    input  logic     shift_dr,
    input  logic     clock_dr,
    input  logic     update_dr,
    input  logic     scan_in,
    input  logic     core_oe,
    input  logic     core_do,
    input  logic     pad_in,
    input  pin_ovr_t ovr,
    output logic     scan_out,
    output logic     upd_oe,
    output logic     upd_do,
    output logic     pad_oe,
    output logic     pad_do
);
    logic en_q;
    logic do_q;
    logic cap_q;

    // Scan stages: serial shift or parallel load on the rising edge.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            do_q  <= 1'b0;
            cap_q <= 1'b0;
        end else if (clock_dr) begin
            if (shift_dr) begin
                en_q  <= scan_in;
                do_q  <= en_q;
                cap_q <= do_q;
            end else begin
                en_q  <= core_oe;
                do_q  <= core_do;
                cap_q <= pad_in;
            end
        end
    end

    // Update stages: transfer enable and data on the falling edge.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            upd_oe <= 1'b0;
            upd_do <= 1'b0;
        end else if (update_dr) begin
            upd_oe <= en_q;
            upd_do <= do_q;
        end
    end

    // Pin driver mux with the driver-off override on top.
    always_comb begin
        logic oe_sel;
        oe_sel   = ovr.use_bscan ? upd_oe : core_oe;
        pad_do   = ovr.use_bscan ? upd_do : core_do;
        pad_oe   = oe_sel & ~ovr.drv_kill;
        scan_out = cap_q;
    end
endmodule

// File: rtl/bsc_input_cell.sv
`timescale 1ns/1ps
// Boundary cell for one input-only pin: a single stage that loads the pin
// on capture and scan_in on shift, on the rising edge when clock_dr is high.
module bsc_input_cell (
    input  logic tck,
    input  logic rst_n,
    input  logic shift_dr,
    input  logic clock_dr,
    input  logic scan_in,
    input  logic pin,
    output logic scan_out
);
    // Single sample/shift stage.
    always_ff @(posedge tck) begin
        if (!rst_n)
            scan_out <= 1'b0;
        else if (clock_dr)
            scan_out <= shift_dr ? scan_in : pin;
    end
endmodule

// File: rtl/bsc_tdo_stage.sv
`timescale 1ns/1ps
// Retimes the last chain stage onto the falling test-clock edge so the
// serial output is stable across the following rising edge.
module bsc_tdo_stage (
    input  logic tck,
    input  logic rst_n,
    input  logic last_bit,
    output logic tdo
);
    // Falling-edge output register.
    always_ff @(negedge tck) begin
        if (!rst_n)
            tdo <= 1'b0;
        else
            tdo <= last_bit;
    end
endmodule

// File: rtl/bsc_chain.sv
`timescale 1ns/1ps
// Boundary-scan chain for NUM_BIDIR bidirectional pins followed by
// NUM_INPUT input-only pins. Strobes come from an external TAP controller.
// Chain order from tdi: per bidirectional pin enable, data, sample; then
// input pins; the last stage feeds tdo through a falling-edge register.
module bsc_chain
    import bsc_pkg::*;
#(
    parameter int NUM_BIDIR = 4,
    parameter int NUM_INPUT = 3
) (
    input  logic                 tck,
    input  logic                 rst_n,
    input  logic                 shift_dr,
    input  logic                 clock_dr,
    input  logic                 update_dr,
    input  logic                 tdi,
    input  logic                 extest,
    input  logic                 prog_mode,
    input  logic                 highz,
    input  logic                 toe_n,
    input  logic [NUM_BIDIR-1:0] core_oe,
    input  logic [NUM_BIDIR-1:0] core_do,
    input  logic [NUM_BIDIR-1:0] pad_in,
    input  logic [NUM_INPUT-1:0] in_pin,
    output logic [NUM_BIDIR-1:0] pad_oe,
    output logic [NUM_BIDIR-1:0] pad_do,
    output logic                 tdo
);
    localparam int NUM_CELLS = NUM_BIDIR + NUM_INPUT;
    localparam int CHAIN_LEN = chain_len(NUM_BIDIR, NUM_INPUT);

    logic [NUM_CELLS:0]   link;
    logic [NUM_BIDIR-1:0] upd_oe_bus;
    logic [NUM_BIDIR-1:0] upd_do_bus;
    pin_ovr_t             ovr;

    // Global override decode shared by all bidirectional cells.
    always_comb begin
        ovr.use_bscan = extest | prog_mode;
        ovr.drv_kill  = highz | ~toe_n;
        link[0]       = tdi;
    end

    // Bidirectional cells in index order at the head of the chain.
    for (genvar b = 0; b < NUM_BIDIR; b++) begin : g_bidir
        bsc_bidir_cell u_cell (
            .tck       (tck),
            .rst_n     (rst_n),
            .shift_dr  (shift_dr),
            .clock_dr  (clock_dr),
            .update_dr (update_dr),
            .scan_in   (link[b]),
            .core_oe   (core_oe[b]),
            .core_do   (core_do[b]),
            .pad_in    (pad_in[b]),
            .ovr       (ovr),
            .scan_out  (link[b+1]),
            .upd_oe    (upd_oe_bus[b]),
            .upd_do    (upd_do_bus[b]),
            .pad_oe    (pad_oe[b]),
            .pad_do    (pad_do[b])
        );
    end

    // Input-only cells in index order after the bidirectional cells.
    for (genvar j = 0; j < NUM_INPUT; j++) begin : g_input
        bsc_input_cell u_cell (
            .tck      (tck),
            .rst_n    (rst_n),
            .shift_dr (shift_dr),
            .clock_dr (clock_dr),
            .scan_in  (link[NUM_BIDIR+j]),
            .pin      (in_pin[j]),
            .scan_out (link[NUM_BIDIR+j+1])
        );
    end

    bsc_tdo_stage u_tdo (
        .tck      (tck),
        .rst_n    (rst_n),
        .last_bit (link[NUM_CELLS]),
        .tdo      (tdo)
    );

    if (CHAIN_LEN < 1) begin : g_len_check
        initial $display("bsc_chain: empty chain");
    end
endmodule

// File: rtl/bsc_chain_chk.sv
`timescale 1ns/1ps
// Checker for bsc_chain: pin override priorities and update-stage timing.
// Sampled on the rising edge; the update stages move on the falling edge.
module bsc_chain_chk #(
    parameter int NB = 4
) (
    input logic          tck,
    input logic          rst_n,
    input logic          update_dr,
    input logic          extest,
    input logic          prog_mode,
    input logic          highz,
    input logic          toe_n,
    input logic [NB-1:0] core_oe,
    input logic [NB-1:0] core_do,
    input logic [NB-1:0] pad_oe,
    input logic [NB-1:0] pad_do,
    input logic [NB-1:0] upd_oe,
    input logic [NB-1:0] upd_do
);
    a_r7_highz_off: assert property (@(posedge tck) disable iff (!rst_n)
        highz |-> (pad_oe == '0));

    a_r8_toe_off: assert property (@(posedge tck) disable iff (!rst_n)
        !toe_n |-> (pad_oe == '0));

    a_r6_core_path: assert property (@(posedge tck) disable iff (!rst_n)
        (!extest && !prog_mode && !highz && toe_n) |->
            (pad_oe == core_oe && pad_do == core_do));

    a_r6_bscan_path: assert property (@(posedge tck) disable iff (!rst_n)
        ((extest || prog_mode) && !highz && toe_n) |->
            (pad_oe == upd_oe && pad_do == upd_do));

    a_r4_update_hold: assert property (@(posedge tck) disable iff (!rst_n)
        !update_dr |=> ($stable(upd_oe) && $stable(upd_do)));

    a_r5_update_clear: assert property (@(posedge tck)
        !rst_n |=> (upd_oe == '0 && upd_do == '0));
endmodule

bind bsc_chain bsc_chain_chk #(.NB(NUM_BIDIR)) u_chk (
    .tck       (tck),
    .rst_n     (rst_n),
    .update_dr (update_dr),
    .extest    (extest),
    .prog_mode (prog_mode),
    .highz     (highz),
    .toe_n     (toe_n),
    .core_oe   (core_oe),
    .core_do   (core_do),
    .pad_oe    (pad_oe),
    .pad_do    (pad_do),
    .upd_oe    (upd_oe_bus),
    .upd_do    (upd_do_bus)
);

// File: tb/sim_bsc_chain.sv
`timescale 1ns/1ps
// Bench for bsc_chain: directed corners plus seeded random strobes,
// checked against a bench-side model of the chain built from the brief.
module sim_bsc_chain;
    localparam int NB = 4;
    localparam int NI = 3;
    localparam int L  = 3 * NB + NI;

    logic tck = 1'b0;
    always #10 tck = ~tck;

    logic rst_n, shift_dr, clock_dr, update_dr, tdi;
    logic extest, prog_mode, highz, toe_n;
    logic [NB-1:0] core_oe, core_do, pad_in, pad_oe, pad_do;
    logic [NI-1:0] in_pin;
    logic tdo;

    bsc_chain #(.NUM_BIDIR(NB), .NUM_INPUT(NI)) u0 (
        .tck(tck), .rst_n(rst_n), .shift_dr(shift_dr), .clock_dr(clock_dr),
        .update_dr(update_dr), .tdi(tdi), .extest(extest),
        .prog_mode(prog_mode), .highz(highz), .toe_n(toe_n),
        .core_oe(core_oe), .core_do(core_do), .pad_in(pad_in),
        .in_pin(in_pin), .pad_oe(pad_oe), .pad_do(pad_do), .tdo(tdo)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [L-1:0]  m_ch;
    logic [NB-1:0] m_uoe, m_udo;
    logic          m_tdo;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [L-1:0] capture_vec();
        logic [L-1:0] v;
        for (int b = 0; b < NB; b++) begin
            v[3*b]   = core_oe[b];
            v[3*b+1] = core_do[b];
            v[3*b+2] = pad_in[b];
        end
        for (int j = 0; j < NI; j++) v[3*NB+j] = in_pin[j];
        return v;
    endfunction

    function automatic logic [NB-1:0] exp_oe();
        logic [NB-1:0] o;
        o = (extest || prog_mode) ? m_uoe : core_oe;
        if (highz || !toe_n) o = '0;
        return o;
    endfunction

    function automatic logic [NB-1:0] exp_do();
        return (extest || prog_mode) ? m_udo : core_do;
    endfunction

    // One test-clock period; entered and left at falling edge + 5 ns.
    task automatic cyc();
        @(posedge tck);
        if (!rst_n) m_ch = '0;
        else if (clock_dr) m_ch = shift_dr ? {m_ch[L-2:0], tdi} : capture_vec();
        #5;
        chk("R9", "tdo before falling edge", tdo, m_tdo);
        @(negedge tck);
        if (!rst_n) begin
            m_uoe = '0; m_udo = '0; m_tdo = 1'b0;
        end else begin
            if (update_dr)
                for (int b = 0; b < NB; b++) begin
                    m_uoe[b] = m_ch[3*b];
                    m_udo[b] = m_ch[3*b+1];
                end
            m_tdo = m_ch[L-1];
        end
        #5;
    endtask

    task automatic check_pads(input string tag);
        chk(tag, "pad_oe", pad_oe, exp_oe());
        chk(tag, "pad_do", pad_do, exp_do());
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        rst_n = 0; shift_dr = 0; clock_dr = 1; update_dr = 1; tdi = 1;
        extest = 1; prog_mode = 0; highz = 0; toe_n = 1;
        core_oe = '1; core_do = '1; pad_in = '1; in_pin = '1;
        m_ch = '0; m_uoe = '0; m_udo = '0; m_tdo = 1'b0;
        @(negedge tck); #5;
        repeat (3) cyc();
        // R5: reset state seen through tdo and the override path
        chk("R5", "tdo after reset", tdo, 0);
        chk("R5", "pad_oe after reset", pad_oe, 0);
        chk("R5", "pad_do after reset", pad_do, 0);
        rst_n = 1; update_dr = 0; extest = 0;

        // R2 then R10: parallel load a known pattern, then shift it out
        core_oe = 4'b1010; core_do = 4'b0110; pad_in = 4'b1100; in_pin = 3'b101;
        clock_dr = 1; shift_dr = 0;
        cyc();
        chk("R2", "tdo after capture", tdo, m_tdo);
        chk("R2", "last input stage", tdo, in_pin[NI-1]);
        shift_dr = 1; tdi = 0;
        for (int k = 0; k < L - 1; k++) begin
            cyc();
            chk("R10", "tdo shift-out order", tdo, m_tdo);
        end

        // R1 and R4: fill chain serially, update, drive pins from update stages
        for (int k = 0; k < L; k++) begin
            tdi = k[0] ^ k[2];
            cyc();
            chk("R1", "tdo during shift", tdo, m_tdo);
        end
        clock_dr = 0; update_dr = 1;
        cyc();
        update_dr = 0; extest = 1; core_oe = ~m_uoe; core_do = ~m_udo;
        #1; check_pads("R4");
        prog_mode = 1; extest = 0;
        #1; check_pads("R6");
        prog_mode = 0; extest = 1;
        // R4: no update pulse, shifting changes nothing at the pins
        clock_dr = 1; shift_dr = 1;
        repeat (4) begin tdi = ~tdi; cyc(); check_pads("R4"); end

        // R3: clock_dr low, tdi toggles, tdo holds
        clock_dr = 0;
        for (int k = 0; k < 4; k++) begin
            tdi = ~tdi; shift_dr = k[0];
            cyc();
            chk("R3", "tdo hold without clock_dr", tdo, m_tdo);
        end

        // R7 and R8 corners
        highz = 1; #1; check_pads("R7");
        highz = 0; toe_n = 0; #1; check_pads("R8");
        toe_n = 1; extest = 0; #1; check_pads("R6");

        // Random mix
        for (int k = 0; k < 600; k++) begin
            logic [31:0] r;
            r = $urandom;
            shift_dr = r[0]; clock_dr = r[1] | r[2]; update_dr = r[3] & r[4];
            tdi = r[5]; extest = r[6] & r[7]; prog_mode = r[8] & r[9] & r[10];
            highz = r[11] & r[12] & r[13]; toe_n = ~(r[14] & r[15] & r[16]);
            core_oe = r[20:17]; core_do = r[24:21]; pad_in = r[28:25];
            in_pin = r[31:29];
            cyc();
            chk(!clock_dr ? "R3" : (shift_dr ? "R1" : "R2"), "tdo", tdo, m_tdo);
            check_pads(highz ? "R7" : (!toe_n ? "R8" : "R6"));
        end

        // R5 mid-run reset
        extest = 1; highz = 0; toe_n = 1; rst_n = 0;
        cyc();
        chk("R5", "tdo cleared", tdo, 0);
        check_pads("R5");
        rst_n = 1;
        cyc();

        done = 1'b1;
        summary();
        $finish;
    end
endmodule